// File: doc/BRIEF.md
# Prioritised UART Interrupt Controller

This block merges the interrupt sources of a serial port into one interrupt line and a 4-bit identification value. It sits beside the receive FIFO, the transmit FIFO and the line-status logic. It sees the receive-FIFO fill level, a vector of line-error event pulses and a pulse that marks the transmit FIFO going empty. It also sees the host strobes that service those sources: a read of the line-status register, a read of the identification register and a write into the transmit FIFO.

Software sets a 3-bit enable mask and a 2-bit receive trigger code. Each source keeps its own pending state, and that state does not depend on the enable mask. Only enabled sources reach the interrupt line. When several are enabled and pending at once, a fixed priority picks the one source the identification value reports. Both outputs are registered.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset, irq is 0, iir is 4'b0001, the enable mask is 000 and the trigger code is 00.
- R2: The enable mask is loaded from ien_wdata when ien_wr is 1. Bit 0 enables the received-data source, bit 1 the transmitter-empty source and bit 2 the line-status source.
- R3: iir bit 0 is 0 while an enabled source is pending and 1 otherwise. Bits [3:1] carry the source ID: 011 line status, 010 received data, 001 transmitter empty, 000 none. With nothing pending, iir is 4'b0001.
- R4: When several enabled sources are pending, iir reports line status first, then received data, then transmitter empty.
- R5: trig_wdata, taken when trig_wr is 1 (bits [7:6] of the FIFO-control byte), selects the receive threshold: 00 is 1 entry, 01 is 16, 10 is 32 and 11 is 56. The received-data source is active while rx_level is greater than or equal to that threshold, and it drops as soon as rx_level falls below it.
- R6: Any 1 bit on line_err sets the line-status pending state. An lsr_rd pulse clears it. If both occur in the same cycle, the state stays set.
- R7: A tx_empty_evt pulse sets the transmitter pending state. A thr_wr pulse clears it, and so does an iir_rd pulse while iir reads 4'b0010. If a set and a clear occur in the same cycle, the state stays set.
- R8: An iir_rd pulse while iir reports a source other than transmitter empty leaves the transmitter pending state unchanged.
- R9: A disabled source does not raise irq. Its pending state is kept, so enabling it later raises irq.
- R10: irq and iir are registered. A change in pending state or in enables appears on the outputs one clock edge later. A change on rx_level appears at the next edge.
- R11: irq is 1 exactly when iir bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien_wr | input | 1 | Write strobe for the enable mask |
| ien_wdata | input | 3 | Enable mask value: {line status, tx empty, rx data} |
| trig_wr | input | 1 | Write strobe for the receive trigger code |
| trig_wdata | input | 2 | Receive trigger code |
| lsr_rd | input | 1 | Host read of the line-status register |
| iir_rd | input | 1 | Host read of the identification register |
| thr_wr | input | 1 | Host write into the transmit FIFO |
| rx_level | input | LVL_W (7) | Receive FIFO occupancy |
| line_err | input | 4 | Line-error event pulses (overrun, parity, framing, break) |
| tx_empty_evt | input | 1 | Pulse when the transmit FIFO becomes empty |
| irq | output | 1 | Interrupt request |
| iir | output | 4 | Identification value: {ID[2:0], pending_n} |

## Verification
The threshold path is swept with occupancy values one below and exactly at each of the four trigger levels, plus a full FIFO. This separates a wrong level table and an off-by-one compare from a correct one. The priority path raises all three sources together and then services them one at a time, so each of the three IDs shows up in order. A reversed priority or a clear wired to the wrong source shows up as a wrong ID. Further patterns cover same-cycle set and clear, a read of iir that must not clear the transmitter while another source is reported, and a source that is latched while masked and then enabled. These catch set-versus-clear ordering mistakes and gating that drops the pending state.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_NONE = 3'b000,
    ID_TX   = 3'b001,
    ID_RX   = 3'b010,
    ID_LS   = 3'b011
  } irq_id_e;

  // source vector positions, highest priority at the top
  localparam int SRC_TX = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_LS = 2;
  localparam int N_SRC  = 3;
endpackage

// File: rtl/irq_sticky.sv
// Pending flag: set has priority over clear (R6, R7)
module irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/irq_rx_level.sv
// Receive threshold selection and compare (R5)
module irq_rx_level #(
  parameter int LVL_W = 7,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 16,
  parameter int TRIG2 = 32,
  parameter int TRIG3 = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_wr,
  input  logic [1:0]       trig_wdata,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_hit
);
  localparam int N_TRIG = 4;
  localparam int TRIG_TAB [N_TRIG] = '{TRIG0, TRIG1, TRIG2, TRIG3};

  logic [1:0]       code_q;
  logic [LVL_W-1:0] lvl_tab [N_TRIG];

  for (genvar gi = 0; gi < N_TRIG; gi++) begin : g_tab
    assign lvl_tab[gi] = LVL_W'(TRIG_TAB[gi]);
  end

  always_ff @(posedge clk) begin
    if (rst)          code_q <= 2'b00;
    else if (trig_wr) code_q <= trig_wdata;
  end

  assign rx_hit = (rx_level >= lvl_tab[code_q]);
endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder with registered outputs (R3, R4, R10, R11)
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_act,
  output logic             irq,
  output logic [3:0]       iir
);
  irq_id_e id_d;

  always_comb begin
    if (src_act[SRC_LS])      id_d = ID_LS;
    else if (src_act[SRC_RX]) id_d = ID_RX;
    else if (src_act[SRC_TX]) id_d = ID_TX;
    else                      id_d = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      iir <= 4'b0001;
    end else begin
      irq <= |src_act;
      iir <= {id_d, ~(|src_act)};
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int ERR_W      = 4,
  parameter int TRIG0      = 1,
  parameter int TRIG1      = 16,
  parameter int TRIG2      = 32,
  parameter int TRIG3      = 56,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_wr,
  input  logic [2:0]       ien_wdata,
  input  logic             trig_wr,
  input  logic [1:0]       trig_wdata,
  input  logic             lsr_rd,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [ERR_W-1:0] line_err,
  input  logic             tx_empty_evt,
  output logic             irq,
  output logic [3:0]       iir
);
  localparam logic [3:0] IIR_TX = {ID_TX, 1'b0};

  logic [N_SRC-1:0] ie_q;
  logic [N_SRC-1:0] src_act;
  logic             ls_pend;
  logic             tx_pend;
  logic             rx_hit;
  logic             tx_clr;

  // enable mask: bit0 rx, bit1 tx, bit2 line status (R2)
  always_ff @(posedge clk) begin
    if (rst)         ie_q <= '0;
    else if (ien_wr) ie_q <= {ien_wdata[2], ien_wdata[0], ien_wdata[1]};
  end

  irq_sticky u_ls (
    .clk    (clk),
    .rst    (rst),
    .set_i  (|line_err),
    .clr_i  (lsr_rd),
    .pend_o (ls_pend)
  );

  // transmitter clears on FIFO write or on a read that reports it (R7, R8)
  assign tx_clr = thr_wr | (iir_rd && (iir == IIR_TX));

  irq_sticky u_tx (
    .clk    (clk),
    .rst    (rst),
    .set_i  (tx_empty_evt),
    .clr_i  (tx_clr),
    .pend_o (tx_pend)
  );

  irq_rx_level #(
    .LVL_W (LVL_W),
    .TRIG0 (TRIG0),
    .TRIG1 (TRIG1),
    .TRIG2 (TRIG2),
    .TRIG3 (TRIG3)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .trig_wr    (trig_wr),
    .trig_wdata (trig_wdata),
    .rx_level   (rx_level),
    .rx_hit     (rx_hit)
  );

  assign src_act[SRC_LS] = ls_pend & ie_q[SRC_LS];
  assign src_act[SRC_RX] = rx_hit  & ie_q[SRC_RX];
  assign src_act[SRC_TX] = tx_pend & ie_q[SRC_TX];

  irq_prio_enc u_enc (
    .clk     (clk),
    .rst     (rst),
    .src_act (src_act),
    .irq     (irq),
    .iir     (iir)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       lsr_rd,
  input logic       iir_rd,
  input logic       thr_wr,
  input logic       err_any,
  input logic       tx_empty_evt,
  input logic       ls_pend,
  input logic       tx_pend,
  input logic [2:0] ie_q,
  input logic       irq,
  input logic [3:0] iir
);
  AST_ERR_SETS_LS: assert property (@(posedge clk) disable iff (rst)
    err_any |=> ls_pend); // R6
  AST_LSR_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !err_any) |=> !ls_pend); // R6
  AST_THR_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !tx_empty_evt) |=> !tx_pend); // R7
  AST_IIR_RD_TX_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && iir == 4'b0010 && !tx_empty_evt) |=> !tx_pend); // R7
  AST_IIR_RD_OTHER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && iir != 4'b0010 && !thr_wr && tx_pend) |=> tx_pend); // R8
  AST_LS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ls_pend && ie_q[2]) |=> (iir == 4'b0110)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ie_q == 3'b000) |=> !irq); // R9
  AST_IRQ_PEND_BIT: assert property (@(posedge clk) disable iff (rst)
    irq |-> !iir[0]); // R11
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (iir == 4'b0001)); // R3
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .lsr_rd       (lsr_rd),
  .iir_rd       (iir_rd),
  .thr_wr       (thr_wr),
  .err_any      (|line_err),
  .tx_empty_evt (tx_empty_evt),
  .ls_pend      (ls_pend),
  .tx_pend      (tx_pend),
  .ie_q         (ie_q),
  .irq          (irq),
  .iir          (iir)
);

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;
  localparam int LVL_W = 7;
  localparam int NVEC  = 9;
  // {trigger code[9:8], rx_level[7:1], expected irq[0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 7'd0,  1'b0}, {2'd0, 7'd1,  1'b1},
    {2'd1, 7'd15, 1'b0}, {2'd1, 7'd16, 1'b1},
    {2'd2, 7'd31, 1'b0}, {2'd2, 7'd32, 1'b1},
    {2'd3, 7'd55, 1'b0}, {2'd3, 7'd56, 1'b1},
    {2'd3, 7'd64, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ien_wr = 0, trig_wr = 0, lsr_rd = 0, iir_rd = 0, thr_wr = 0;
  logic [2:0]       ien_wdata = 0;
  logic [1:0]       trig_wdata = 0;
  logic [LVL_W-1:0] rx_level = 0;
  logic [3:0]       line_err = 0;
  logic             tx_empty_evt = 0;
  logic             irq;
  logic [3:0]       iir;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .trig_wr(trig_wr), .trig_wdata(trig_wdata), .lsr_rd(lsr_rd),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .rx_level(rx_level),
    .line_err(line_err), .tx_empty_evt(tx_empty_evt), .irq(irq), .iir(iir)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // end a strobe cycle: release all pulses, let outputs register
  task automatic settle();
    cyc();
    ien_wr = 0; trig_wr = 0; lsr_rd = 0; iir_rd = 0; thr_wr = 0;
    line_err = 0; tx_empty_evt = 0;
    cyc();
  endtask

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {irq,iir} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R1 reset", {irq, iir}, 5'b0_0001);
    // R5 threshold table
    ien_wdata = 3'b001; ien_wr = 1; settle();
    for (int i = 0; i < NVEC; i++) begin
      trig_wdata = VEC[i][9:8]; trig_wr = 1;
      rx_level = VEC[i][7:1];
      settle();
      chk($sformatf("R5 vec%0d", i), {irq, iir},
          VEC[i][0] ? 5'b1_0100 : 5'b0_0001);
    end
    rx_level = 0; trig_wdata = 0; trig_wr = 1; settle();
    // R4 all sources together, then service one by one
    ien_wdata = 3'b111; ien_wr = 1; rx_level = 1;
    line_err = 4'b0100; tx_empty_evt = 1; settle();
    chk("R4 ls first", {irq, iir}, 5'b1_0110);
    iir_rd = 1; settle();
    chk("R8 iir_rd keeps tx (ls shown)", {irq, iir}, 5'b1_0110);
    lsr_rd = 1; settle();
    chk("R6 lsr_rd clears ls, rx next", {irq, iir}, 5'b1_0100);
    iir_rd = 1; settle();
    chk("R8 iir_rd keeps tx (rx shown)", {irq, iir}, 5'b1_0100);
    rx_level = 0; cyc();
    chk("R10 rx drop visible after one edge", {irq, iir}, 5'b1_0010);
    iir_rd = 1; settle();
    chk("R7 iir_rd clears tx", {irq, iir}, 5'b0_0001);
    // R7 thr_wr clear and set-wins
    tx_empty_evt = 1; settle();
    chk("R7 tx set", {irq, iir}, 5'b1_0010);
    thr_wr = 1; settle();
    chk("R7 thr_wr clears", {irq, iir}, 5'b0_0001);
    tx_empty_evt = 1; thr_wr = 1; settle();
    chk("R7 set wins over clear", {irq, iir}, 5'b1_0010);
    thr_wr = 1; settle();
    // R6 set wins
    line_err = 4'b0001; lsr_rd = 1; settle();
    chk("R6 set wins over read", {irq, iir}, 5'b1_0110);
    lsr_rd = 1; settle();
    chk("R11 idle after service", {irq, iir}, 5'b0_0001);
    // R9 masked source latched then enabled; R2 bit mapping
    ien_wdata = 3'b011; ien_wr = 1; line_err = 4'b1000; settle();
    chk("R9 masked ls quiet", {irq, iir}, 5'b0_0001);
    ien_wdata = 3'b100; ien_wr = 1; settle();
    chk("R2 bit2 enables ls", {irq, iir}, 5'b1_0110);
    lsr_rd = 1; tx_empty_evt = 1; settle();
    chk("R2 bit1 masked by mask 100", {irq, iir}, 5'b0_0001);
    ien_wdata = 3'b010; ien_wr = 1; settle();
    chk("R2 bit1 enables tx", {irq, iir}, 5'b1_0010);
    // R1 reset mid-run
    rst = 1; cyc(); rst = 0; rx_level = 1; cyc();
    chk("R1 reset clears mask", {irq, iir}, 5'b0_0001);
    finish_run();
  end
endmodule